// File: doc/BRIEF.md
# Synchronous Serial Clock Edge Unit

This block turns a serial bit clock into the two single-cycle timing strobes that the transmit and receive shift logic of a synchronous serial port needs: `tx_change`, the cycle in which the next transmit bit is to be put out, and `rx_sample`, the cycle in which the incoming bit is to be captured. Both strobes are produced in the system clock domain. The transmit and receive edges are always opposite edges of the serial clock. The `polarity` input decides which edge is which.

As clock master, the block makes the serial clock itself with a down-counting divider. It drives the clock out with its output enable asserted. As clock slave, it takes the serial clock from outside and passes it through a two-flop synchronizer and an edge detector. Only the detector's pulses reach the strobe path, two system clock cycles after the pin changes. Master and slave edge events share one strobe path.

A three-state sequencer controls the block. `ST_OFF` holds every register at the idle clock level, which equals `polarity`. `ST_MASTER` runs the divider and `ST_SLAVE` runs the synchronizer. The transitions are:
- OFF to MASTER when `enable` and `master` are sampled high.
- OFF to SLAVE when `enable` is high and `master` is low.
- MASTER or SLAVE back to OFF when `enable` drops, when `master` no longer matches the active state, or when `polarity` differs from the value latched on leaving OFF.

OFF always lasts at least one cycle, so every start reloads the idle level and the divider count.

Top module: `usart_sclk_edges`

## Requirements
- R1: While `rst_n` is low, `tx_change`, `rx_sample` and `sclk_oe` are 0 and `sclk_out` equals `polarity`.
- R2: While `enable` is low, no strobe is produced, `sclk_oe` is 0, `sclk_out` equals `polarity`, and toggling `sclk_in` has no effect.
- R3: In master mode `sclk_oe` is 1. `sclk_out` first leaves its idle level `div_val`+1 cycles after the first clk edge that samples `enable` and `master` high. After that it toggles every `div_val`+1 cycles.
- R4: With `polarity` 0 the idle level is 0, `tx_change` marks rising serial clock edges and `rx_sample` marks falling ones.
- R5: With `polarity` 1 the idle level is 1, `tx_change` marks falling serial clock edges and `rx_sample` marks rising ones.
- R6: In master mode each strobe is high in the same cycle in which `sclk_out` first shows the new level.
- R7: In slave mode `sclk_oe` is 0 and `sclk_out` stays at `polarity`. A change of `sclk_in` that is set up before clk edge k gives its strobe in the cycle after edge k+1, which is a latency of two cycles.
- R8: Each strobe is exactly one clk cycle wide, and `tx_change` and `rx_sample` are never high together.
- R9: A `polarity` change while active returns the block to OFF for one cycle, then restarts it. In master mode the first new edge comes `div_val`+2 cycles after the edge that samples the change, and it is a `tx_change` edge.
- R10: After reset or on entering slave mode with `sclk_in` at the idle level, no strobe is produced until `sclk_in` actually changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Synchronous mode on |
| master | input | 1 | 1: block drives the serial clock, 0: serial clock comes from outside |
| polarity | input | 1 | Edge selection and idle level |
| div_val | input | DIV_W | Master half period minus one, in clk cycles |
| sclk_in | input | 1 | External serial clock (slave) |
| sclk_out | output | 1 | Serial clock value to drive on the pin |
| sclk_oe | output | 1 | Serial clock pin output enable |
| tx_change | output | 1 | One-cycle strobe: shift out the next transmit bit |
| rx_sample | output | 1 | One-cycle strobe: capture the receive bit |

## Verification
The slave-path properties take for granted that `sclk_in` stays at the idle level whenever the block enters slave mode. They also take for granted that it changes no faster than once every three clk cycles, which keeps its frequency below a quarter of clk. The master-level properties apply only where `polarity` has been steady for a cycle. The stimulus enables slave mode with `sclk_in` parked at the selected idle level and toggles it at half periods of three and four cycles. It changes `polarity` only while the block is off, except in the deliberate restart case. Strobe timing is checked against cycle numbers computed from the requirements. This covers the divider period at `div_val` 0, 3 and 5, and the two-cycle slave latency.

// File: rtl/usart_sclk_pkg.sv
package usart_sclk_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_MASTER = 2'd1,
        ST_SLAVE  = 2'd2
    } sclk_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

endpackage

// File: rtl/sclk_sync.sv
module sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_val,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            chain_q <= {STAGES{load_val}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sclk_edge_detect.sv
module sclk_edge_detect
    import usart_sclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  logic     load_val,
    input  logic     lvl,
    output edge_ev_t ev
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            prev_q <= load_val;
        end else begin
            prev_q <= lvl;
        end
    end

    always_comb begin
        ev.rise = lvl & ~prev_q;
        ev.fall = ~lvl & prev_q;
    end
endmodule

// File: rtl/sclk_master_div.sv
module sclk_master_div
    import usart_sclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             load_val,
    input  logic [DIV_W-1:0] div_val,
    output logic             sclk,
    output edge_ev_t         ev
);
    localparam logic [DIV_W-1:0] CNT_ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic             sclk_q;
    edge_ev_t         ev_q;

    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            sclk_q <= load_val;
            cnt_q  <= div_val;
            ev_q   <= '0;
        end else if (cnt_q == '0) begin
            sclk_q    <= ~sclk_q;
            cnt_q     <= div_val;
            ev_q.rise <= ~sclk_q;
            ev_q.fall <= sclk_q;
        end else begin
            cnt_q <= cnt_q - CNT_ONE;
            ev_q  <= '0;
        end
    end

    assign sclk = sclk_q;
    assign ev   = ev_q;
endmodule

// File: rtl/usart_sclk_edges.sv
module usart_sclk_edges
    import usart_sclk_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             master,
    input  logic             polarity,
    input  logic [DIV_W-1:0] div_val,
    input  logic             sclk_in,
    output logic             sclk_out,
    output logic             sclk_oe,
    output logic             tx_change,
    output logic             rx_sample
);
    sclk_state_t state_q, state_d;
    logic        pol_q;
    logic        clear;
    logic        m_sclk;
    logic        s_lvl;
    edge_ev_t    m_ev, s_ev, sel_ev;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            pol_q   <= polarity;
        end else begin
            state_q <= state_d;
            if (state_q == ST_OFF) begin
                pol_q <= polarity;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (enable && master)       state_d = ST_MASTER;
                else if (enable)            state_d = ST_SLAVE;
            end
            ST_MASTER: begin
                if (!enable || !master || (polarity != pol_q)) state_d = ST_OFF;
            end
            ST_SLAVE: begin
                if (!enable || master || (polarity != pol_q))  state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        clear    = 1'b0;
        sclk_oe  = 1'b0;
        sclk_out = polarity;
        sel_ev   = '0;
        unique case (state_q)
            ST_OFF: begin
                clear = 1'b1;
            end
            ST_MASTER: begin
                sclk_oe  = 1'b1;
                sclk_out = m_sclk;
                sel_ev   = m_ev;
            end
            ST_SLAVE: begin
                sclk_out = pol_q;
                sel_ev   = s_ev;
            end
            default: clear = 1'b1;
        endcase
        tx_change = pol_q ? sel_ev.fall : sel_ev.rise;
        rx_sample = pol_q ? sel_ev.rise : sel_ev.fall;
    end

    sclk_master_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (clear),
        .load_val (polarity),
        .div_val  (div_val),
        .sclk     (m_sclk),
        .ev       (m_ev)
    );

    sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (clear),
        .load_val (polarity),
        .d        (sclk_in),
        .q        (s_lvl)
    );

    sclk_edge_detect u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (clear),
        .load_val (polarity),
        .lvl      (s_lvl),
        .ev       (s_ev)
    );
endmodule

// File: rtl/usart_sclk_edges_chk.sv
module usart_sclk_edges_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic master,
    input logic polarity,
    input logic sclk_in,
    input logic sclk_out,
    input logic sclk_oe,
    input logic tx_change,
    input logic rx_sample
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!tx_change && !rx_sample && !sclk_oe));

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_change && rx_sample));

    a_r8_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_change |=> !tx_change);

    a_r8_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sample |=> !rx_sample);

    a_r2_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sclk_oe && !tx_change && !rx_sample));

    a_r3_oe_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        (!master || !enable) |=> !sclk_oe);

    a_r4_master_tx_level: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_oe && tx_change && $stable(polarity)) |-> (sclk_out != polarity));

    // R5: the sample edge lands on the idle level of the chosen polarity
    a_r5_master_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_oe && rx_sample && $stable(polarity)) |-> (sclk_out == polarity));

    a_r6_master_strobe_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_oe && (tx_change || rx_sample)) |-> (sclk_out != $past(sclk_out)));

    a_r7_slave_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_oe && (tx_change || rx_sample)) |-> ($past(sclk_in, 2) != $past(sclk_in, 3)));
endmodule

bind usart_sclk_edges usart_sclk_edges_chk u_chk (.*);

// File: tb/usart_sclk_edges_bench.sv
`timescale 1ns/1ps
module usart_sclk_edges_bench;
    localparam int DIV_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic master = 1'b0;
    logic polarity = 1'b0;
    logic [DIV_W-1:0] div_val = '0;
    logic sclk_in = 1'b0;
    logic sclk_out, sclk_oe, tx_change, rx_sample;

    typedef struct {
        int t;
        bit tx;
        bit lvl;
        bit oe;
        bit pol;
    } exp_t;

    exp_t exp_q[$];
    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    int strobe_cnt = 0;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    usart_sclk_edges #(.DIV_W(DIV_W)) u_usart_sclk_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .master    (master),
        .polarity  (polarity),
        .div_val   (div_val),
        .sclk_in   (sclk_in),
        .sclk_out  (sclk_out),
        .sclk_oe   (sclk_oe),
        .tx_change (tx_change),
        .rx_sample (rx_sample)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int t, input bit tx, input bit lvl, input bit oe, input bit pol);
        exp_t e;
        e.t = t; e.tx = tx; e.lvl = lvl; e.oe = oe; e.pol = pol;
        exp_q.push_back(e);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && (tx_change || rx_sample)) begin
            strobe_cnt++;
            if (tx_change && rx_sample) begin
                check(1'b0, "R8", "both strobes high", 1, 0);
            end else if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected strobe at cycle", cyc, -1);
            end else begin
                e = exp_q.pop_front();
                check(e.t == cyc, e.oe ? "R3" : "R7", "strobe cycle", cyc, e.t);
                check(tx_change == e.tx, e.pol ? "R5" : "R4", "strobe is tx_change",
                      int'(tx_change), int'(e.tx));
                check(sclk_out == e.lvl, e.oe ? "R6" : "R7", "sclk_out at strobe",
                      int'(sclk_out), int'(e.lvl));
                check(sclk_oe == e.oe, e.oe ? "R3" : "R7", "sclk_oe at strobe",
                      int'(sclk_oe), int'(e.oe));
            end
        end
    end

    task automatic run_master(input bit pol, input int d, input int nedges, input bit flip);
        int n;
        int last;
        @(negedge clk);
        polarity = pol;
        div_val  = d[DIV_W-1:0];
        master   = 1'b1;
        enable   = 1'b1;
        n = cyc;
        last = n;
        for (int k = 0; k < nedges; k++) begin
            last = n + d + 2 + k * (d + 1);
            push(last, (k % 2) == 0, ((k % 2) == 0) ? !pol : pol, 1'b1, pol);
        end
        wait_until(last);
        if (flip) begin
            // R9: restart after a polarity change while running
            polarity = !pol;
            n = cyc;
            for (int k = 0; k < nedges; k++) begin
                last = n + d + 3 + k * (d + 1);
                push(last, (k % 2) == 0, ((k % 2) == 0) ? pol : !pol, 1'b1, !pol);
            end
            wait_until(last);
        end
        enable = 1'b0;
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, flip ? "R9" : "R3", "master events left", exp_q.size(), 0);
        check(!sclk_oe && sclk_out == polarity, "R2", "pin idle after disable",
              int'(sclk_oe), 0);
    endtask

    task automatic run_slave(input bit pol, input int half, input int nedges);
        @(negedge clk);
        polarity = pol;
        sclk_in  = pol;
        master   = 1'b0;
        enable   = 1'b1;
        repeat (3) @(negedge clk);
        for (int k = 0; k < nedges; k++) begin
            sclk_in = ~sclk_in;
            push(cyc + 2, (k % 2) == 0, pol, 1'b0, pol);
            repeat (half) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R7", "slave events left", exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired at cycle", cyc, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        check(!tx_change && !rx_sample && !sclk_oe && sclk_out == 1'b0, "R1",
              "reset outputs, polarity 0", int'({tx_change, rx_sample, sclk_oe, sclk_out}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: disabled, external clock toggles are ignored
        s0 = strobe_cnt;
        master = 1'b0;
        for (int k = 0; k < 8; k++) begin
            sclk_in = ~sclk_in;
            repeat (3) @(negedge clk);
        end
        check(strobe_cnt == s0, "R2", "strobes while disabled", strobe_cnt - s0, 0);
        check(!sclk_oe && sclk_out == polarity, "R2", "pin while disabled", int'(sclk_oe), 0);

        run_master(1'b0, 3, 6, 1'b0);
        run_master(1'b1, 0, 8, 1'b0);
        run_master(1'b0, 5, 4, 1'b1);
        run_slave(1'b0, 3, 6);
        run_slave(1'b1, 4, 6);

        // R10: reset with polarity 1, enter slave with sclk_in idle
        @(negedge clk);
        rst_n = 1'b0;
        polarity = 1'b1;
        sclk_in = 1'b1;
        repeat (3) @(negedge clk);
        check(!tx_change && !rx_sample && !sclk_oe && sclk_out == 1'b1, "R1",
              "reset outputs, polarity 1", int'(sclk_out), 1);
        rst_n = 1'b1;
        enable = 1'b1;
        master = 1'b0;
        s0 = strobe_cnt;
        repeat (8) @(negedge clk);
        check(strobe_cnt == s0, "R10", "false strobe after reset", strobe_cnt - s0, 0);
        sclk_in = 1'b0;
        push(cyc + 2, 1'b1, 1'b1, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10", "first real edge missing", exp_q.size(), 0);
        enable = 1'b0;
        repeat (3) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule